// File: doc/BRIEF.md
# Masked Pattern Trigger and Timestamp Monitor

This block watches a stream of wide data words, each qualified by a valid strobe, and raises three registered outputs from them. One is a collected-data strobe together with the collected word. The other two are a trigger pulse and a timestamp-request pulse. Each of the two pulses comes from its own masked comparator, with its own pattern and its own mask.

A small word-addressed register interface holds the configuration. A control register enables the unit and chooses between two collection modes. In continuous mode every valid word is collected. In change-only mode a word is collected only when it differs from the last collected word. A separate register gates the timestamp comparator. Each pattern and each mask is split into 32-bit halves: index 0 holds bits 31:0 of the data word and index 1 holds bits 63:32.

Top module: `trace_match_monitor`

## Requirements
- R1: After reset every register reads 0, and `coll_valid`, `trig_pulse` and `ts_req` are low.
- R2: The pattern and mask halves read back the full 32 bits last written. The register map is:
  - 0xA08/0xA0C: timestamp pattern, index 0/1
  - 0xA10/0xA14: timestamp mask, index 0/1
  - 0xA18/0xA1C: trigger pattern, index 0/1
  - 0xA20/0xA24: trigger mask, index 0/1
  - 0xA00: control, which reads back only bit 0 (enable) and bit 1 (mode); all other bits read 0
  - 0xA04: timestamp enable, which reads back only bit 0

  Any other address reads 0.
- R3: While control bit 0 is 0, no valid word produces `coll_valid`, `trig_pulse` or `ts_req`.
- R4: With the unit enabled, `trig_pulse` is high for exactly the one cycle after a valid word in which every data bit whose trigger-mask bit is 1 equals the corresponding trigger-pattern bit. Data bits whose mask bit is 0 are not compared.
- R5: An all-zero mask matches every valid word.
- R6: `ts_req` is high for the one cycle after a valid, matching word under the timestamp pattern and mask, and only when bit 0 at 0xA04 is 1.
- R7: In continuous mode (control bit 1 = 0), every valid word gives `coll_valid` high in the next cycle, with `coll_data` equal to that word.
- R8: In change-only mode (control bit 1 = 1), a valid word is collected only if it differs from the last collected word. The first valid word after the unit is enabled is always collected.
- R9: In a cycle after which no valid word was presented, all three strobes are low.
- R10: A register write takes effect for a valid word presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| din_valid | input | 1 | Input word valid |
| din_data | input | 64 | Input data word |
| coll_valid | output | 1 | Collected-data strobe |
| coll_data | output | 64 | Last collected word |
| trig_pulse | output | 1 | Trigger pulse |
| ts_req | output | 1 | Timestamp-request pulse |

## Verification
The hardest case to reach is the change-only history. The stored word persists across mode switches and across disable, and the only way to observe it is through which later words are collected. The stimulus therefore first collects a known word in continuous mode. It then switches to change-only mode and repeats, alternates and returns to earlier words, so the effects of the first-word rule and the last-word comparison can be told apart. The masked comparators are driven with masks that split across both 32-bit halves. Words are chosen to flip one compared bit or only ignored bits.

// File: rtl/tmm_pkg.sv
package tmm_pkg;
  localparam int unsigned OFS_CTRL  = 'hA00;
  localparam int unsigned OFS_TSEN  = 'hA04;
  localparam int unsigned OFS_TSPAT = 'hA08;
  localparam int unsigned OFS_TSMSK = 'hA10;
  localparam int unsigned OFS_TRPAT = 'hA18;
  localparam int unsigned OFS_TRMSK = 'hA20;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_MODE_BIT = 1;
endpackage

// File: rtl/tmm_regs.sv
module tmm_regs import tmm_pkg::*; #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              ctl_en,
  output logic              ctl_mode,
  output logic              ts_en,
  output logic [DATA_W-1:0] ts_pat,
  output logic [DATA_W-1:0] ts_msk,
  output logic [DATA_W-1:0] tr_pat,
  output logic [DATA_W-1:0] tr_msk
);
  localparam int unsigned NW = DATA_W / REG_W;

  logic [REG_W-1:0] tspat_q [NW];
  logic [REG_W-1:0] tsmsk_q [NW];
  logic [REG_W-1:0] trpat_q [NW];
  logic [REG_W-1:0] trmsk_q [NW];
  logic             en_q, mode_q, tsen_q;

  function automatic logic hit_addr(input logic [ADDR_W-1:0] a,
                                    input int unsigned base, input int unsigned idx);
    return a == ADDR_W'(base + 4 * idx);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      tsen_q <= 1'b0;
      for (int i = 0; i < NW; i++) begin
        tspat_q[i] <= '0;
        tsmsk_q[i] <= '0;
        trpat_q[i] <= '0;
        trmsk_q[i] <= '0;
      end
    end else if (reg_wr) begin
      if (hit_addr(reg_addr, OFS_CTRL, 0)) begin
        en_q   <= reg_wdata[CTRL_EN_BIT];
        mode_q <= reg_wdata[CTRL_MODE_BIT];
      end
      if (hit_addr(reg_addr, OFS_TSEN, 0)) tsen_q <= reg_wdata[0];
      for (int i = 0; i < NW; i++) begin
        if (hit_addr(reg_addr, OFS_TSPAT, i)) tspat_q[i] <= reg_wdata;
        if (hit_addr(reg_addr, OFS_TSMSK, i)) tsmsk_q[i] <= reg_wdata;
        if (hit_addr(reg_addr, OFS_TRPAT, i)) trpat_q[i] <= reg_wdata;
        if (hit_addr(reg_addr, OFS_TRMSK, i)) trmsk_q[i] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_addr(reg_addr, OFS_CTRL, 0)) begin
      reg_rdata[CTRL_EN_BIT]   = en_q;
      reg_rdata[CTRL_MODE_BIT] = mode_q;
    end
    if (hit_addr(reg_addr, OFS_TSEN, 0)) reg_rdata[0] = tsen_q;
    for (int i = 0; i < NW; i++) begin
      if (hit_addr(reg_addr, OFS_TSPAT, i)) reg_rdata = tspat_q[i];
      if (hit_addr(reg_addr, OFS_TSMSK, i)) reg_rdata = tsmsk_q[i];
      if (hit_addr(reg_addr, OFS_TRPAT, i)) reg_rdata = trpat_q[i];
      if (hit_addr(reg_addr, OFS_TRMSK, i)) reg_rdata = trmsk_q[i];
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_join
    assign ts_pat[g*REG_W +: REG_W] = tspat_q[g];
    assign ts_msk[g*REG_W +: REG_W] = tsmsk_q[g];
    assign tr_pat[g*REG_W +: REG_W] = trpat_q[g];
    assign tr_msk[g*REG_W +: REG_W] = trmsk_q[g];
  end

  assign ctl_en   = en_q;
  assign ctl_mode = mode_q;
  assign ts_en    = tsen_q;

  // R2: control readback carries nothing beyond its two defined bits
  a_r2_ctrl_rd_bits: assert property (@(posedge clk) disable iff (!rst_n)
    hit_addr(reg_addr, OFS_CTRL, 0) |-> (reg_rdata[REG_W-1:2] == '0));
endmodule

// File: rtl/tmm_cmp.sv
module tmm_cmp #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              gate,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] pat,
  input  logic [DATA_W-1:0] msk,
  output logic              hit,
  output logic              pulse
);
  function automatic logic masked_eq(input logic [DATA_W-1:0] d,
                                     input logic [DATA_W-1:0] p,
                                     input logic [DATA_W-1:0] m);
    return ((d ^ p) & m) == '0;
  endfunction

  assign hit = masked_eq(data, pat, msk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= strobe & gate & hit;
  end

  // R4: a pulse always traces back to a strobed word
  a_r4_pulse_from_word: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(strobe && gate));
  // R5: nothing compared means always a hit
  a_r5_zero_mask_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && gate && msk == '0) |=> pulse);
endmodule

// File: rtl/tmm_collect.sv
module tmm_collect #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mode_chg,
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  output logic              coll_valid,
  output logic [DATA_W-1:0] coll_data
);
  logic              first_q;
  logic [DATA_W-1:0] last_q;
  logic              differs;
  logic              take;

  assign differs = (data != last_q);
  assign take    = en & valid & (~mode_chg | first_q | differs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q    <= 1'b1;
      last_q     <= '0;
      coll_valid <= 1'b0;
    end else begin
      coll_valid <= take;
      if (!en)       first_q <= 1'b1;
      else if (take) first_q <= 1'b0;
      if (take)      last_q  <= data;
    end
  end

  assign coll_data = last_q;

  // R8: a repeated word in change-only mode is dropped
  a_r8_repeat_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (en && valid && mode_chg && !first_q && !differs) |=> !coll_valid);
  // R8: first word after enable is kept
  a_r8_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (en && valid && first_q) |=> coll_valid);
  // R7: continuous mode keeps every word with its data
  a_r7_cont_all: assert property (@(posedge clk) disable iff (!rst_n)
    (en && valid && !mode_chg) |=> (coll_valid && coll_data == $past(data)));
endmodule

// File: rtl/trace_match_monitor.sv
module trace_match_monitor #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din_data,
  output logic              coll_valid,
  output logic [DATA_W-1:0] coll_data,
  output logic              trig_pulse,
  output logic              ts_req
);
  logic              ctl_en, ctl_mode, ts_en;
  logic [DATA_W-1:0] ts_pat, ts_msk, tr_pat, tr_msk;
  logic              ts_hit, tr_hit;
  logic              word_in;

  assign word_in = din_valid & ctl_en;

  tmm_regs #(.DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_en(ctl_en),
    .ctl_mode(ctl_mode), .ts_en(ts_en), .ts_pat(ts_pat), .ts_msk(ts_msk),
    .tr_pat(tr_pat), .tr_msk(tr_msk)
  );

  tmm_cmp #(.DATA_W(DATA_W)) u_trig_cmp (
    .clk(clk), .rst_n(rst_n), .strobe(word_in), .gate(1'b1),
    .data(din_data), .pat(tr_pat), .msk(tr_msk), .hit(tr_hit), .pulse(trig_pulse)
  );

  tmm_cmp #(.DATA_W(DATA_W)) u_ts_cmp (
    .clk(clk), .rst_n(rst_n), .strobe(word_in), .gate(ts_en),
    .data(din_data), .pat(ts_pat), .msk(ts_msk), .hit(ts_hit), .pulse(ts_req)
  );

  tmm_collect #(.DATA_W(DATA_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .mode_chg(ctl_mode),
    .valid(din_valid), .data(din_data), .coll_valid(coll_valid), .coll_data(coll_data)
  );

  // R3 / R9: no accepted word, no strobe of any kind
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(din_valid && ctl_en) |=> (!coll_valid && !trig_pulse && !ts_req));
  // R6: timestamp request requires the enable bit in the prior cycle
  a_r6_ts_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ts_req |-> $past(ts_en));
  // R4: an accepted matching word always triggers
  a_r4_match_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (word_in && tr_hit) |=> trig_pulse);
  // R6: an accepted, enabled timestamp match always requests
  a_r6_ts_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (word_in && ts_en && ts_hit) |=> ts_req);
endmodule

// File: tb/trace_match_monitor_tb.sv
module trace_match_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        din_valid = 1'b0;
  logic [63:0] din_data = '0;
  logic        coll_valid;
  logic [63:0] coll_data;
  logic        trig_pulse, ts_req;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  trace_match_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .din_valid(din_valid),
    .din_data(din_data), .coll_valid(coll_valid), .coll_data(coll_data),
    .trig_pulse(trig_pulse), .ts_req(ts_req)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, $sformatf("read %h", a), {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  // present one word; outputs are checked in the cycle after it
  task automatic word(input string req, input logic [63:0] d,
                      input logic ec, input logic et, input logic es);
    @(negedge clk);
    din_valid = 1'b1; din_data = d;
    @(negedge clk);
    din_valid = 1'b0;
    check(req, "coll_valid", {63'h0, coll_valid}, {63'h0, ec});
    check(req, "trig_pulse", {63'h0, trig_pulse}, {63'h0, et});
    check(req, "ts_req",     {63'h0, ts_req},     {63'h0, es});
    if (ec) check(req, "coll_data", coll_data, d);
  endtask

  function automatic logic mhit(input logic [63:0] d, input logic [63:0] p, input logic [63:0] m);
    for (int b = 0; b < 64; b++)
      if (m[b] && (d[b] != p[b])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_reset;
    check("R1", "coll_valid", {63'h0, coll_valid}, 64'h0);
    check("R1", "trig_pulse", {63'h0, trig_pulse}, 64'h0);
    check("R1", "ts_req",     {63'h0, ts_req},     64'h0);
    rd_check("R1", 12'hA00, 32'h0);
    rd_check("R1", 12'hA08, 32'h0);
    rd_check("R1", 12'hA24, 32'h0);
  endtask

  task automatic t_readback;
    wr(12'hA08, 32'h1111_0001); wr(12'hA0C, 32'h2222_0002);
    wr(12'hA10, 32'h3333_0003); wr(12'hA14, 32'h4444_0004);
    wr(12'hA18, 32'h5555_0005); wr(12'hA1C, 32'h6666_0006);
    wr(12'hA20, 32'h7777_0007); wr(12'hA24, 32'h8888_0008);
    wr(12'hA00, 32'hFFFF_FFFC); wr(12'hA04, 32'hFFFF_FFFF);
    rd_check("R2", 12'hA08, 32'h1111_0001); rd_check("R2", 12'hA0C, 32'h2222_0002);
    rd_check("R2", 12'hA10, 32'h3333_0003); rd_check("R2", 12'hA14, 32'h4444_0004);
    rd_check("R2", 12'hA18, 32'h5555_0005); rd_check("R2", 12'hA1C, 32'h6666_0006);
    rd_check("R2", 12'hA20, 32'h7777_0007); rd_check("R2", 12'hA24, 32'h8888_0008);
    rd_check("R2", 12'hA00, 32'h0);
    rd_check("R2", 12'hA04, 32'h1);
    wr(12'hA00, 32'h3);
    rd_check("R2", 12'hA00, 32'h3);
    rd_check("R2", 12'hA28, 32'h0);
    for (int i = 0; i < 8; i++) wr(12'hA08 + 12'(4 * i), 32'h0);
    wr(12'hA00, 32'h0); wr(12'hA04, 32'h0);
  endtask

  task automatic t_disabled;
    word("R3", 64'hDEAD_BEEF_0000_0001, 1'b0, 1'b0, 1'b0);
    wr(12'hA04, 32'h1);
    word("R3", 64'hDEAD_BEEF_0000_0002, 1'b0, 1'b0, 1'b0);
    wr(12'hA04, 32'h0);
  endtask

  task automatic t_zero_mask;
    wr(12'hA00, 32'h1);
    word("R5", 64'h0123_4567_89AB_CDEF, 1'b1, 1'b1, 1'b0);
    word("R5", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_trigger;
    logic [63:0] p, m, d;
    p = 64'hA500_0000_0000_005A; m = 64'hFF00_0000_0000_00FF;
    wr(12'hA18, p[31:0]); wr(12'hA1C, p[63:32]);
    wr(12'hA20, m[31:0]); wr(12'hA24, m[63:32]);
    d = 64'hA512_3456_789A_BC5A;
    word("R4", d, 1'b1, mhit(d, p, m), 1'b0);
    d = 64'hA512_3456_789A_BC5B;
    word("R4", d, 1'b1, mhit(d, p, m), 1'b0);
    d = 64'hA400_0000_0000_005A;
    word("R4", d, 1'b1, mhit(d, p, m), 1'b0);
    d = 64'hA5FF_FFFF_FFFF_FF5A;
    word("R7", d, 1'b1, mhit(d, p, m), 1'b0);
  endtask

  task automatic t_timestamp;
    logic [63:0] p, m, d;
    p = 64'h1234_5678_9ABC_DEF0; m = '1;
    wr(12'hA08, p[31:0]); wr(12'hA0C, p[63:32]);
    wr(12'hA10, m[31:0]); wr(12'hA14, m[63:32]);
    d = p;
    word("R6", d, 1'b1, 1'b0, 1'b0);
    wr(12'hA04, 32'h1);
    word("R6", d, 1'b1, 1'b0, mhit(d, p, m));
    d = p ^ 64'h8000_0000_0000_0000;
    word("R6", d, 1'b1, 1'b0, mhit(d, p, m));
    wr(12'hA04, 32'h0);
    for (int i = 0; i < 8; i++) wr(12'hA08 + 12'(4 * i), 32'h0);
  endtask

  task automatic t_change;
    logic [63:0] a, b;
    a = 64'h0000_0000_AAAA_AAAA; b = 64'h5555_5555_0000_0000;
    word("R7", a, 1'b1, 1'b1, 1'b0);
    wr(12'hA00, 32'h3);
    word("R8", a, 1'b0, 1'b1, 1'b0);
    word("R8", b, 1'b1, 1'b1, 1'b0);
    word("R8", b, 1'b0, 1'b1, 1'b0);
    word("R8", a, 1'b1, 1'b1, 1'b0);
    wr(12'hA00, 32'h2);
    wr(12'hA00, 32'h3);
    word("R8", a, 1'b1, 1'b1, 1'b0);
    word("R8", a, 1'b0, 1'b1, 1'b0);
    wr(12'hA00, 32'h1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    check("R9", "coll_valid", {63'h0, coll_valid}, 64'h0);
    check("R9", "trig_pulse", {63'h0, trig_pulse}, 64'h0);
    check("R9", "ts_req",     {63'h0, ts_req},     64'h0);
  endtask

  task automatic t_write_then_word;
    wr(12'hA20, 32'h0000_0001);
    word("R10", 64'h0, 1'b1, 1'b1, 1'b0);
    wr(12'hA18, 32'h0000_0001);
    word("R10", 64'h2, 1'b1, 1'b0, 1'b0);
    wr(12'hA00, 32'h0);
    word("R10", 64'h1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_readback;
    t_disabled;
    t_zero_mask;
    t_trigger;
    t_timestamp;
    t_change;
    t_idle;
    t_write_then_word;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule